// File: doc/BRIEF.md
# Indirect Branch Target Predictor

This block guesses where an indirect branch will go, using a direct-mapped table of the target that was last seen at each slot. The table has no tags and no valid bits. The slot is chosen from a few bits of the branch address. Each request carries the branch address together with the target that the branch actually resolved to. The block reads the slot, returns the stored target as the prediction and flags a mispredict when it differs from the resolved target. In the same cycle it writes the resolved target into the slot. It does this whether the guess was right or wrong. Branches whose addresses map to the same slot therefore share it and overwrite each other.

After reset the controller is in state CLEAR. It zeroes one slot per cycle and holds `req_ready` low until every slot is empty. The transition CLEAR→RUN happens on the cycle the last slot is written. From RUN the only transition is back to CLEAR, taken on reset from any state. In RUN a request is accepted whenever `req_valid` is high, one per cycle. Its response appears the following cycle as a single-cycle `rsp_valid` pulse. Two saturating counters report the accepted lookups and the mispredicts.

Top module: `indirect_target_pred`

## Requirements
- R1: While reset is high, and for exactly 2^IDX_W cycles after it is released, `req_ready` is 0. It then rises to 1 and stays there until the next reset. During reset `rsp_valid` and both counters are 0.
- R2: The slot index is `req_addr[LO_ZERO +: IDX_W]`. Address bits below and above that field have no effect on which slot is used.
- R3: A request accepted at a rising edge (`req_valid` and `req_ready` both 1) produces `rsp_valid`=1 for exactly one cycle after that edge. In that cycle `rsp_pred` holds the slot contents as they were before the access.
- R4: `rsp_miss` is 1 exactly when `rsp_pred` differs from the resolved target of the same request.
- R5: Every accepted request writes its resolved target into its slot, whether it hit or missed. A request to the same slot in the very next cycle already predicts that target.
- R6: Two addresses with equal index fields share one slot, each overwriting the target stored by the other.
- R7: After the clear sweep every slot predicts 0.
- R8: `lookup_cnt` counts accepted requests and holds at 2^CNT_W-1 instead of wrapping.
- R9: `miss_cnt` counts responses with `rsp_miss`=1 and holds at 2^CNT_W-1.
- R10: A request presented while `req_ready` is 0 is ignored. It produces no response, changes neither counter and writes no slot.
- R11: A reset taken after slots have been written clears the whole table again, along with both counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; starts the clear sweep |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block accepts requests (state RUN) |
| req_addr | input | ADDR_W | Branch address |
| req_target | input | ADDR_W | Resolved target of the branch |
| rsp_valid | output | 1 | One-cycle pulse after an accepted request |
| rsp_pred | output | ADDR_W | Predicted target (previous slot contents) |
| rsp_miss | output | 1 | Prediction differed from the resolved target |
| lookup_cnt | output | CNT_W | Saturating count of accepted requests |
| miss_cnt | output | CNT_W | Saturating count of mispredicts |

## Verification
Two functions can fall in the same cycle: the write of one request's target into its slot, and the read of that slot by the request that immediately follows. The bench provokes this by holding `req_valid` high across two consecutive cycles. It does so both with equal addresses and with aliasing addresses that differ only outside the index field. The second response is judged correct only if it predicts the first request's target. A second coincidence is a counter that is already saturated receiving a mispredict. The bench drives more than 2^CNT_W consecutive misses and expects both counters to stop at their ceiling.

// File: rtl/itp_pkg.sv
package itp_pkg;
    typedef enum logic [0:0] {
        ST_CLEAR = 1'b0,
        ST_RUN   = 1'b1
    } itp_state_e;
endpackage

// File: rtl/itp_ctrl.sv
module itp_ctrl
    import itp_pkg::*;
#(
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    output logic             ready,
    output logic             clr_we,
    output logic [IDX_W-1:0] clr_idx
);
    localparam logic [IDX_W-1:0] LAST = {IDX_W{1'b1}};

    itp_state_e       state;
    logic [IDX_W-1:0] ptr;

    // state register and sweep pointer
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_CLEAR;
            ptr   <= '0;
        end else begin
            unique case (state)
                ST_CLEAR: begin
                    ptr <= ptr + 1'b1;
                    if (ptr == LAST) state <= ST_RUN;
                end
                ST_RUN: begin
                    ptr <= ptr;
                end
                default: state <= ST_CLEAR;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        ready   = 1'b0;
        clr_we  = 1'b0;
        clr_idx = ptr;
        unique case (state)
            ST_CLEAR: clr_we = 1'b1;
            ST_RUN:   ready  = 1'b1;
            default:  ready  = 1'b0;
        endcase
    end

    // R1
    run_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);

    // R1
    clear_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_we && !ready) |=> (ptr == $past(ptr) + 1'b1));

    // R1
    ready_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        (!ready && ptr == LAST) |=> ready);
endmodule

// File: rtl/itp_table.sv
module itp_table #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] slots [DEPTH];

    always_ff @(posedge clk) begin
        if (we) slots[widx] <= wdata;
    end

    assign rdata = slots[ridx];

    // R5
    write_visible_chk: assert property (@(posedge clk) disable iff (rst)
        (we && !$isunknown(wdata)) ##1 (ridx == $past(widx)) |-> (rdata == $past(wdata)));
endmodule

// File: rtl/itp_satcnt.sv
module itp_satcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst)                      count <= '0;
        else if (inc && count != TOP) count <= count + 1'b1;
    end

    // R8
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (count == TOP) |=> (count == TOP));

    // R9
    unit_step_chk: assert property (@(posedge clk) disable iff (rst)
        (count == $past(count)) || (count == $past(count) + 1'b1));
endmodule

// File: rtl/indirect_target_pred.sv
module indirect_target_pred #(
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = 9,
    parameter int LO_ZERO = 2,
    parameter int CNT_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W-1:0] req_target,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_pred,
    output logic              rsp_miss,
    output logic [CNT_W-1:0]  lookup_cnt,
    output logic [CNT_W-1:0]  miss_cnt
);
    logic              fire;
    logic [IDX_W-1:0]  idx;
    logic              clr_we;
    logic [IDX_W-1:0]  clr_idx;
    logic              tbl_we;
    logic [IDX_W-1:0]  tbl_widx;
    logic [ADDR_W-1:0] tbl_wdata;
    logic [ADDR_W-1:0] stored;
    logic              differs;
    logic              unused_addr_bits;

    assign idx              = req_addr[LO_ZERO +: IDX_W];
    assign unused_addr_bits = ^req_addr;
    assign fire             = req_valid && req_ready;
    assign differs          = (stored != req_target);

    itp_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .ready   (req_ready),
        .clr_we  (clr_we),
        .clr_idx (clr_idx)
    );

    // clear sweep and requests never overlap: requests only in RUN
    assign tbl_we    = clr_we | fire;
    assign tbl_widx  = clr_we ? clr_idx : idx;
    assign tbl_wdata = clr_we ? '0 : req_target;

    itp_table #(.DATA_W(ADDR_W), .IDX_W(IDX_W)) u_table (
        .clk   (clk),
        .rst   (rst),
        .we    (tbl_we),
        .widx  (tbl_widx),
        .wdata (tbl_wdata),
        .ridx  (idx),
        .rdata (stored)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_pred  <= '0;
            rsp_miss  <= 1'b0;
        end else begin
            rsp_valid <= fire;
            if (fire) begin
                rsp_pred <= stored;
                rsp_miss <= differs;
            end
        end
    end

    itp_satcnt #(.W(CNT_W)) u_lookups (
        .clk   (clk),
        .rst   (rst),
        .inc   (fire),
        .count (lookup_cnt)
    );

    itp_satcnt #(.W(CNT_W)) u_misses (
        .clk   (clk),
        .rst   (rst),
        .inc   (fire && differs),
        .count (miss_cnt)
    );

    // R3
    rsp_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> rsp_valid);

    // R3
    rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !fire |=> !rsp_valid);

    // R4
    miss_meaning_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> (rsp_miss == (rsp_pred != $past(req_target))));

    // R5
    back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && $past(fire) && idx == $past(idx)) |=> (rsp_pred == $past(req_target, 2)));

    // R10
    idle_counts_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !fire |=> ($stable(lookup_cnt) && $stable(miss_cnt)));

    // R9
    cnt_order_chk: assert property (@(posedge clk) disable iff (rst)
        miss_cnt <= lookup_cnt);
endmodule

// File: tb/sim_indirect_target_pred.sv
module sim_indirect_target_pred;
    localparam int AW    = 16;
    localparam int IW    = 4;
    localparam int LZ    = 1;
    localparam int CW    = 6;
    localparam int DEPTH = 1 << IW;
    localparam int CMAX  = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [AW-1:0] req_target = '0;
    logic          rsp_valid;
    logic [AW-1:0] rsp_pred;
    logic          rsp_miss;
    logic [CW-1:0] lookup_cnt;
    logic [CW-1:0] miss_cnt;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [AW-1:0] model [DEPTH];
    int exp_look = 0;
    int exp_miss = 0;

    always #2 clk = ~clk;

    indirect_target_pred #(.ADDR_W(AW), .IDX_W(IW), .LO_ZERO(LZ), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_target(req_target), .rsp_valid(rsp_valid),
        .rsp_pred(rsp_pred), .rsp_miss(rsp_miss), .lookup_cnt(lookup_cnt),
        .miss_cnt(miss_cnt)
    );

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000) begin
            errors <= errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int index_of(input logic [AW-1:0] a);
        return int'((a >> LZ) & (DEPTH - 1));
    endfunction

    // presented at a negedge; leaves the bench at the next negedge
    task automatic access(input logic [AW-1:0] a, input logic [AW-1:0] t,
                          input bit keep, input string tag);
        int i;
        logic [AW-1:0] ep;
        bit em;
        req_valid  = 1'b1;
        req_addr   = a;
        req_target = t;
        i  = index_of(a);
        ep = model[i];
        em = (ep != t);
        model[i] = t;
        if (exp_look < CMAX) exp_look++;
        if (em && exp_miss < CMAX) exp_miss++;
        @(posedge clk);
        @(negedge clk);
        if (!keep) req_valid = 1'b0;
        chk(rsp_valid == 1'b1, "R3 rsp_valid", longint'(rsp_valid), 1);
        chk(rsp_pred == ep, tag, longint'(rsp_pred), longint'(ep));
        chk(rsp_miss == em, "R4 rsp_miss", longint'(rsp_miss), longint'(em));
        chk(int'(lookup_cnt) == exp_look, "R8 lookup_cnt", longint'(lookup_cnt), exp_look);
        chk(int'(miss_cnt) == exp_miss, "R9 miss_cnt", longint'(miss_cnt), exp_miss);
    endtask

    // reset; optionally drive a request during the first part of the sweep
    task automatic do_reset(input bit poke);
        int n;
        bit seen;
        rst = 1'b1;
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b0, "R1 ready in reset", longint'(req_ready), 0);
        chk(rsp_valid == 1'b0, "R1 rsp_valid in reset", longint'(rsp_valid), 0);
        chk(lookup_cnt == '0 && miss_cnt == '0, "R11 counters in reset",
            longint'({lookup_cnt, miss_cnt}), 0);
        rst = 1'b0;
        for (int k = 0; k < DEPTH; k++) model[k] = '0;
        exp_look = 0;
        exp_miss = 0;
        if (poke) begin
            req_valid  = 1'b1;
            req_addr   = AW'(5 << LZ);
            req_target = 16'h5A5A;
        end
        n = 0;
        seen = 1'b0;
        while (!req_ready && n < 4 * DEPTH) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (rsp_valid) seen = 1'b1;
            if (n == DEPTH - 2) req_valid = 1'b0;
        end
        chk(n == DEPTH, "R1 clear length", n, DEPTH);
        if (poke) begin
            chk(!seen, "R10 no response while not ready", longint'(seen), 0);
            chk(lookup_cnt == '0 && miss_cnt == '0, "R10 counters untouched",
                longint'({lookup_cnt, miss_cnt}), 0);
        end
    endtask

    initial begin
        do_reset(1'b0);

        // R7: every slot empty, target 0 hits
        for (int i = 0; i < DEPTH; i++)
            access(AW'(i << LZ), '0, 1'b0, "R7 empty slot predicts 0");
        // fill all slots: each misses against 0
        for (int i = 0; i < DEPTH; i++)
            access(AW'((i << LZ) | (i << 9)), AW'(16'hA000 + i * 37), 1'b0, "R7 fill");
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R3 single pulse", longint'(rsp_valid), 0);
        // R5: repeat hits, R2: low and high bits varied
        for (int i = 0; i < DEPTH; i++)
            access(AW'((i << LZ) | 1 | ((DEPTH - 1 - i) << 11)), AW'(16'hA000 + i * 37),
                   1'b0, "R2 outer bits ignored");

        // R6 aliasing pair
        for (int k = 0; k < 4; k++) begin
            access(AW'((3 << LZ) | 16'h0100), 16'h1111, 1'b0, "R6 alias a");
            access(AW'((3 << LZ) | 16'h0200), 16'h2222, 1'b0, "R6 alias b");
        end

        // R5 back-to-back, same address and aliasing address
        access(AW'(7 << LZ), 16'h3333, 1'b1, "R5 b2b first");
        access(AW'(7 << LZ), 16'h4444, 1'b1, "R5 b2b same addr");
        access(AW'((7 << LZ) | 16'h8000), 16'h4444, 1'b0, "R5 b2b alias hit");

        // R11 + R10: reset with a request pending during the sweep
        do_reset(1'b1);
        access(AW'(5 << LZ), 16'h5A5A, 1'b0, "R11 slot cleared by reset");
        access(AW'(3 << LZ), 16'h2222, 1'b0, "R11 slot cleared by reset");

        // R8 R9 saturation: consecutive misses
        for (int k = 0; k < CMAX + 10; k++)
            access(AW'(9 << LZ), AW'(k[0] ? 16'hBEEF : 16'hCAFE), 1'b1, "R9 saturating run");
        req_valid = 1'b0;
        @(negedge clk);
        chk(int'(lookup_cnt) == CMAX, "R8 lookup held", longint'(lookup_cnt), CMAX);
        chk(int'(miss_cnt) == CMAX, "R9 miss held", longint'(miss_cnt), CMAX);

        finish_run();
    end
endmodule